// File: doc/BRIEF.md
# Sleep Entry and Wake Controller

This block decides when a processor core stops its clock for a low-power sleep and when it may run again. A strobe that tells the block a sleep instruction has retired puts the core to sleep, but only while the standby-select bit of the block's configuration register is clear. While asleep, the core's clock is gated through the halt output and its registers keep their contents. Peripheral clocks are not touched, so timers, DMA and interrupt sources keep running and can wake the core.

Wake sources are maskable interrupt requests, a DMA address-error pulse, a qualified edge on the non-maskable interrupt pin, and the active-low reset pin. A maskable request wakes the core only if its source has it enabled and its priority is strictly above the current CPU mask level. The reset pin leaves sleep at once, and the level of the synchronized NMI pin while reset is low selects a power-on reset or a manual reset. A 2-bit cause code records why the core last came out of sleep or reset.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While running, a sleep strobe with configuration bit 7 (standby select) at 0 raises cpuHalt on the next clock edge.
- R2: A sleep strobe while configuration bit 7 is 1 has no effect: cpuHalt stays 0.
- R3: Configuration register: bit 7 is standby select and bit 6 is the NMI valid edge (1 = rising, 0 = falling). Both are writable and reset to 0. Bit 5 always reads 0 and bits 4 to 0 always read 1, whatever is written, so the reset value reads 8'h1F.
- R4: While asleep, cpuHalt stays 1 when no wake source qualifies. A request whose priority is equal to or below maskLevel, or whose enable bit is 0, does not qualify.
- R5: While asleep, a requested and enabled interrupt whose priority is strictly above maskLevel wakes the core with wakeCause 2'b00.
- R6: A DMA address-error pulse while asleep wakes the core with wakeCause 2'b01. It takes precedence over an interrupt in the same cycle.
- R7: The NMI pin passes through a two-flop synchronizer. While asleep, an edge of the selected polarity wakes the core with wakeCause 2'b00 whatever maskLevel is. An edge of the other polarity does not wake it.
- R8: cpuHalt falls one clock after the clock edge that registers a wake. For an input sampled at edge n, cpuHalt is still 1 after edge n and is 0 after edge n+1.
- R9: While resetN is low, cpuHalt is 0 from the first edge on. wakeCause is 2'b10 and rstManual is 0 if the synchronized NMI pin is high, and wakeCause is 2'b11 and rstManual is 1 if it is low. Reset overrides any other wake source in the same cycle.
- R10: wakeCause changes only on a wake or a reset. Wake sources such as a DMA error have no effect while the core is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (kept running in sleep) |
| resetN | input | 1 | Active-low reset pin, sampled synchronously |
| sleepStrobe | input | 1 | One-cycle pulse: sleep instruction executed |
| cfgWe | input | 1 | Configuration register write enable |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data |
| nmiPin | input | 1 | Asynchronous NMI pin level |
| irqReq | input | NUM_SRC | Per-source interrupt request |
| irqEn | input | NUM_SRC | Per-source enable set by the owning module |
| irqPrio | input | NUM_SRC*PRIO_W | Packed priorities, source i at bits i*PRIO_W upward |
| maskLevel | input | PRIO_W | Current CPU interrupt mask level |
| dmaErr | input | 1 | DMA address-error pulse |
| cpuHalt | output | 1 | CPU clock halt, 1 while asleep |
| wakeCause | output | 2 | 00 interrupt, 01 DMA error, 10 power-on reset, 11 manual reset |
| rstManual | output | 1 | Type of the last reset: 1 manual, 0 power-on |

## Verification
The hardest situations to create from the ports are the ones where two conditions must meet in one cycle or where the NMI history must be set up in advance. For reset against a pending DMA error, the bench lowers resetN and raises dmaErr on the same falling edge while the core is asleep. For an NMI edge of the wrong polarity, the valid edge is switched to rising, the pin is lowered during sleep and the core must stay halted, and only then is the pin raised. For the reset type, the NMI level is held for several cycles before reset so that the synchronized copy has settled.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_SLEEP = 2'b01,
    ST_WAKE  = 2'b10
  } sleepState_e;

  typedef struct packed {
    logic armed;     // core is asleep, wake sources are evaluated
    logic loadWake;  // capture the wake cause this cycle
  } ctlStrobe_t;

  localparam logic [1:0] CAUSE_INT = 2'b00;
  localparam logic [1:0] CAUSE_DMA = 2'b01;
  localparam logic [1:0] CAUSE_POR = 2'b10;
  localparam logic [1:0] CAUSE_MAN = 2'b11;

  localparam int CFG_SBY_BIT  = 7;
  localparam int CFG_EDGE_BIT = 6;
endpackage

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 4
) (
  input  logic                      clk,
  input  logic                      resetN,
  input  ctlStrobe_t                strb,
  input  logic                      cfgWe,
  input  logic [7:0]                cfgWdata,
  output logic [7:0]                cfgRdata,
  input  logic                      nmiPin,
  input  logic [NUM_SRC-1:0]        irqReq,
  input  logic [NUM_SRC-1:0]        irqEn,
  input  logic [NUM_SRC*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         maskLevel,
  input  logic                      dmaErr,
  output logic                      wakeAny,
  output logic                      sbySel,
  output logic [1:0]                wakeCause,
  output logic                      rstManual
);
  localparam int SYNC_DEPTH = 2;

  logic                  edgeSel;
  logic [SYNC_DEPTH-1:0] nmiSync;
  logic                  nmiPrev;
  logic                  nmiLevel;
  logic                  nmiEdge;
  logic [NUM_SRC-1:0]    srcWake;
  logic                  irqWake;
  logic                  dmaWake;
  logic [1:0]            causeCode;

  // configuration register
  always_ff @(posedge clk) begin
    if (!resetN) begin
      sbySel  <= 1'b0;
      edgeSel <= 1'b0;
    end else if (cfgWe) begin
      sbySel  <= cfgWdata[CFG_SBY_BIT];
      edgeSel <= cfgWdata[CFG_EDGE_BIT];
    end
  end

  assign cfgRdata = {sbySel, edgeSel, 1'b0, 5'b11111};

  // NMI synchronizer and edge detector, free running so the level is
  // valid while reset is low
  always_ff @(posedge clk) begin
    nmiSync <= {nmiSync[SYNC_DEPTH-2:0], nmiPin};
    nmiPrev <= nmiSync[SYNC_DEPTH-1];
  end

  assign nmiLevel = nmiSync[SYNC_DEPTH-1];
  assign nmiEdge  = edgeSel ? (nmiLevel & ~nmiPrev) : (~nmiLevel & nmiPrev);

  // per-source qualification: requested, enabled, above the mask
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcWake[i] = irqReq[i] & irqEn[i] &
                        (irqPrio[i*PRIO_W +: PRIO_W] > maskLevel);
  end

  assign irqWake = strb.armed & ((|srcWake) | nmiEdge);
  assign dmaWake = strb.armed & dmaErr;
  assign wakeAny = irqWake | dmaWake;

  always_comb begin
    causeCode = CAUSE_INT;
    if (dmaWake) causeCode = CAUSE_DMA;
  end

  // cause and reset-type registers
  always_ff @(posedge clk) begin
    if (!resetN) begin
      wakeCause <= nmiLevel ? CAUSE_POR : CAUSE_MAN;
      rstManual <= ~nmiLevel;
    end else if (strb.loadWake) begin
      wakeCause <= causeCode;
    end
  end
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_pkg::*;
(
  input  logic       clk,
  input  logic       resetN,
  input  logic       sleepStrobe,
  input  logic       sbySel,
  input  logic       wakeAny,
  output ctlStrobe_t strb,
  output logic       cpuHalt,
  output logic       sleepActive
);
  sleepState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_RUN:   if (sleepStrobe && !sbySel) stateNxt = ST_SLEEP;
      ST_SLEEP: if (wakeAny) stateNxt = ST_WAKE;
      ST_WAKE:  stateNxt = ST_RUN;
      default:  stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!resetN) state <= ST_RUN;
    else         state <= stateNxt;
  end

  assign sleepActive   = (state == ST_SLEEP);
  assign strb.armed    = sleepActive;
  assign strb.loadWake = sleepActive & wakeAny;
  assign cpuHalt       = (state != ST_RUN);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 4
) (
  input  logic                      clk,
  input  logic                      resetN,
  input  logic                      sleepStrobe,
  input  logic                      cfgWe,
  input  logic [7:0]                cfgWdata,
  output logic [7:0]                cfgRdata,
  input  logic                      nmiPin,
  input  logic [NUM_SRC-1:0]        irqReq,
  input  logic [NUM_SRC-1:0]        irqEn,
  input  logic [NUM_SRC*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         maskLevel,
  input  logic                      dmaErr,
  output logic                      cpuHalt,
  output logic [1:0]                wakeCause,
  output logic                      rstManual
);
  ctlStrobe_t strb;
  logic       wakeAny;
  logic       sbySel;
  logic       sleepActive;

  sleep_dp #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .resetN(resetN), .strb(strb),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .nmiPin(nmiPin), .irqReq(irqReq), .irqEn(irqEn), .irqPrio(irqPrio),
    .maskLevel(maskLevel), .dmaErr(dmaErr), .wakeAny(wakeAny),
    .sbySel(sbySel), .wakeCause(wakeCause), .rstManual(rstManual)
  );

  sleep_ctl u_ctl (
    .clk(clk), .resetN(resetN), .sleepStrobe(sleepStrobe), .sbySel(sbySel),
    .wakeAny(wakeAny), .strb(strb), .cpuHalt(cpuHalt),
    .sleepActive(sleepActive)
  );
endmodule

// File: rtl/sleep_wake_chk.sv
module sleep_wake_chk (
  input logic       clk,
  input logic       resetN,
  input logic       sleepStrobe,
  input logic [7:0] cfgRdata,
  input logic       dmaErr,
  input logic       cpuHalt,
  input logic [1:0] wakeCause,
  input logic       sleepActive,
  input logic       wakeAny
);
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!resetN)
    (!cpuHalt && sleepStrobe && !cfgRdata[7]) |=> cpuHalt); // R1

  AST_STANDBY_IGNORED: assert property (@(posedge clk) disable iff (!resetN)
    (!cpuHalt && sleepStrobe && cfgRdata[7]) |=> !cpuHalt); // R2

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!resetN)
    (sleepActive && !wakeAny) |=> cpuHalt); // R4

  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!resetN)
    (sleepActive && dmaErr) |=> (wakeCause == 2'b01)); // R6

  AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (!resetN)
    (sleepActive && wakeAny) |=> (cpuHalt ##1 !cpuHalt)); // R8

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!resetN)
    !(sleepActive && wakeAny) |=> $stable(wakeCause)); // R10
endmodule

bind sleep_wake_ctrl sleep_wake_chk u_chk (
  .clk(clk), .resetN(resetN), .sleepStrobe(sleepStrobe),
  .cfgRdata(cfgRdata), .dmaErr(dmaErr), .cpuHalt(cpuHalt),
  .wakeCause(wakeCause), .sleepActive(sleepActive), .wakeAny(wakeAny)
);

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_wake_ctrl;
  localparam int NUM_SRC = 4;
  localparam int PRIO_W  = 4;

  logic                      clk = 1'b0;
  logic                      resetN = 1'b0;
  logic                      sleepStrobe = 1'b0;
  logic                      cfgWe = 1'b0;
  logic [7:0]                cfgWdata = 8'h00;
  logic [7:0]                cfgRdata;
  logic                      nmiPin = 1'b1;
  logic [NUM_SRC-1:0]        irqReq = '0;
  logic [NUM_SRC-1:0]        irqEn = '0;
  logic [NUM_SRC*PRIO_W-1:0] irqPrio = '0;
  logic [PRIO_W-1:0]         maskLevel = '0;
  logic                      dmaErr = 1'b0;
  logic                      cpuHalt;
  logic [1:0]                wakeCause;
  logic                      rstManual;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) dut (
    .clk(clk), .resetN(resetN), .sleepStrobe(sleepStrobe), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .nmiPin(nmiPin),
    .irqReq(irqReq), .irqEn(irqEn), .irqPrio(irqPrio),
    .maskLevel(maskLevel), .dmaErr(dmaErr), .cpuHalt(cpuHalt),
    .wakeCause(wakeCause), .rstManual(rstManual)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic nmiLvl);
    nmiPin = nmiLvl;
    waitN(4);
    resetN = 1'b0;
    waitN(3);
    resetN = 1'b1;
    waitN(1);
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWdata = d;
    cfgWe = 1'b1;
    waitN(1);
    cfgWe = 1'b0;
  endtask

  task automatic enterSleep(input string tag);
    sleepStrobe = 1'b1;
    waitN(1);
    sleepStrobe = 1'b0;
    check({tag, " R1 halt after strobe"}, cpuHalt, 1);
  endtask

  task automatic t_por_reset();
    doReset(1'b1);
    check("R9 por halt", cpuHalt, 0);
    check("R9 por cause", wakeCause, 2);
    check("R9 por type", rstManual, 0);
    check("R3 reset read", cfgRdata, 8'h1F);
  endtask

  task automatic t_cfg_reg();
    cfgWrite(8'hFF);
    check("R3 write ones", cfgRdata, 8'hDF);
    cfgWrite(8'h00);
    check("R3 write zeros", cfgRdata, 8'h1F);
  endtask

  task automatic t_standby();
    cfgWrite(8'h80);
    sleepStrobe = 1'b1;
    waitN(1);
    sleepStrobe = 1'b0;
    check("R2 standby strobe", cpuHalt, 0);
    waitN(2);
    check("R2 standby later", cpuHalt, 0);
  endtask

  task automatic t_nmi();
    cfgWrite(8'h40);
    maskLevel = 4'hF;
    enterSleep("nmi");
    nmiPin = 1'b0;
    waitN(6);
    check("R7 wrong edge keeps halt", cpuHalt, 1);
    nmiPin = 1'b1;
    waitN(6);
    check("R7 rising edge wakes", cpuHalt, 0);
    check("R7 nmi cause", wakeCause, 0);
  endtask

  task automatic t_dma();
    maskLevel = 4'd2;
    irqPrio = 16'h0900;
    enterSleep("dma");
    dmaErr = 1'b1;
    irqReq = 4'b0100;
    irqEn = 4'b0100;
    waitN(1);
    dmaErr = 1'b0;
    irqReq = '0;
    irqEn = '0;
    check("R8 halt one edge after", cpuHalt, 1);
    waitN(1);
    check("R8 halt released", cpuHalt, 0);
    check("R6 dma over irq cause", wakeCause, 1);
  endtask

  task automatic t_irq();
    maskLevel = 4'd5;
    irqPrio = 16'h0950;   // src1 prio 5, src2 prio 9
    enterSleep("irq");
    irqReq = 4'b0110;
    irqEn = 4'b0010;      // src2 disabled, src1 equal to mask
    waitN(4);
    check("R4 masked or disabled stay asleep", cpuHalt, 1);
    check("R4 cause unchanged", wakeCause, 1);
    irqEn = 4'b0110;
    waitN(1);
    check("R8 irq halt one edge after", cpuHalt, 1);
    irqReq = '0;
    irqEn = '0;
    waitN(1);
    check("R5 irq wake halt", cpuHalt, 0);
    check("R5 irq cause", wakeCause, 0);
  endtask

  task automatic t_run_ignore();
    dmaErr = 1'b1;
    waitN(1);
    dmaErr = 1'b0;
    waitN(2);
    check("R10 running dma halt", cpuHalt, 0);
    check("R10 running dma cause", wakeCause, 0);
  endtask

  task automatic t_manual_reset();
    doReset(1'b0);
    check("R9 manual cause", wakeCause, 3);
    check("R9 manual type", rstManual, 1);
    check("R9 manual halt", cpuHalt, 0);
  endtask

  task automatic t_reset_beats();
    nmiPin = 1'b1;
    waitN(5);
    enterSleep("rst");
    resetN = 1'b0;
    dmaErr = 1'b1;
    waitN(1);
    check("R9 reset over dma halt", cpuHalt, 0);
    check("R9 reset over dma cause", wakeCause, 2);
    check("R9 reset over dma type", rstManual, 0);
    dmaErr = 1'b0;
    resetN = 1'b1;
    waitN(2);
    check("R9 after reset cause", wakeCause, 2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_por_reset();
    t_cfg_reg();
    t_standby();
    t_nmi();
    t_dma();
    t_irq();
    t_run_ignore();
    t_manual_reset();
    t_reset_beats();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule